// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a 10-bit successive-approximation converter that starts a conversion when its chip select falls. The link runs with the serial clock idling low and data taken on rising edges. On a start request the controller lowers chip select while the clock is low. It then waits a set number of system cycles so the converter can power up, and produces exactly sixteen serial clock periods from a divided system clock. It captures one data bit per rising edge and raises chip select on the sixteenth falling edge.

Each frame arrives MSB first and holds three header ones, a channel bit, ten result bits (most significant first) and two sub-bits. When the frame completes, the controller presents the channel, the result and the sub-bits with a one-cycle valid strobe. It also flags a frame error if the header is not all ones. An abort input ends a frame early and discards it. The controller then keeps chip select high for a minimum number of cycles before it accepts another request, both after a normal frame and after an abort.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after reset, chip select is high, the serial clock is low, busy is low and the valid strobe is low.
- R2: A start request seen in idle with abort low drives chip select low on the next cycle, while the serial clock is low. A start request in any other state is ignored.
- R3: The serial clock stays low for WAKE_CYC cycles after chip select falls. The first rising edge follows after a further DIV_HALF cycles.
- R4: While a frame shifts, the serial clock alternates every DIV_HALF system cycles, starting low. It gives exactly 16 rising edges per frame and is low whenever chip select is high.
- R5: The data input is sampled in the last system cycle before each rising serial clock edge. The first sampled bit is frame bit 15, and later bits follow in order down to bit 0.
- R6: Chip select rises on the 16th falling serial clock edge. The valid strobe is high for exactly one cycle, the first cycle in which chip select is high again.
- R7: Output fields come from frame bits: bit 12 is the channel, bits 11..2 the result (bit 11 is the result MSB), and bits 1..0 the sub-bits. The fields hold their values until the next valid strobe.
- R8: The frame-error flag, updated with the valid strobe, is 1 exactly when any of frame bits 15..13 is 0.
- R9: After chip select rises, it stays high for at least CSH_CYC cycles. A start request held high restarts a frame on the first idle cycle.
- R10: An abort while chip select is low raises chip select and forces the serial clock low on the next cycle. It gives no valid strobe, leaves the output fields unchanged, and still applies the CSH_CYC high time. An abort in idle has no effect.
- R11: Busy is high from the cycle after an accepted start until the cycle after the minimum chip-select high time ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request |
| abort_i | input | 1 | Abandon the frame in progress |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Frame or chip-select recovery in progress |
| res_valid_o | output | 1 | One-cycle strobe for a completed frame |
| res_chan_o | output | 1 | Channel bit of the last frame |
| res_data_o | output | 10 | Conversion result of the last frame |
| res_sub_o | output | 2 | Sub-bits of the last frame |
| res_ferr_o | output | 1 | Header of the last frame was not all ones |

## Verification
On every cycle the assertions check the framing rules. Chip select falls only with the clock low, the clock toggles only while chip select is low, and the wake-up and high-time minimums hold on every chip-select edge. The strobe coincides with chip select rising and lasts one cycle, busy covers every low chip-select cycle, and an abort closes the frame on the next cycle. Only the bench's scenarios show that the bits land in the right fields, in the right order and at the right edges. They also show that the header check flags a corrupt frame, that requests during a frame are dropped, and that an aborted frame leaves the previous result in place.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int HDR_BITS   = 3;
  localparam int DATA_BITS  = 10;
  localparam int SUB_BITS   = 2;
  localparam int CHAN_POS   = FRAME_BITS - HDR_BITS - 1;
  localparam int FCNT_W     = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;

  typedef struct packed {
    logic                 chan;
    logic [DATA_BITS-1:0] data;
    logic [SUB_BITS-1:0]  sub;
    logic                 ferr;
  } rd_result_t;
endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_p,
  output logic fall_p
);
  localparam int DW = $clog2(DIV_HALF + 1);
  localparam logic [DW-1:0] RELOAD = DW'(DIV_HALF - 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    if (!run) begin
      cnt_d  = RELOAD;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = RELOAD;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q - 1'b1;
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk   = sclk_q;
  assign rise_p = tick && !sclk_q;
  assign fall_p = tick && sclk_q;
endmodule

// File: rtl/adc_rd_deframe.sv
module adc_rd_deframe
  import adc_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       sdo,
  input  logic       load,
  output rd_result_t result,
  output logic       valid
);
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  rd_result_t            res_q, res_d;
  logic                  valid_q;

  always_comb begin
    sr_d  = shift_en ? {sr_q[FRAME_BITS-2:0], sdo} : sr_q;
    res_d = res_q;
    if (load) begin
      res_d.chan = sr_q[CHAN_POS];
      res_d.data = sr_q[CHAN_POS-1 -: DATA_BITS];
      res_d.sub  = sr_q[SUB_BITS-1:0];
      res_d.ferr = ~&sr_q[FRAME_BITS-1 -: HDR_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      res_q   <= res_d;
      valid_q <= load;
    end
  end

  assign result = res_q;
  assign valid  = valid_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF = 50,
  parameter int WAKE_CYC = 500,
  parameter int CSH_CYC  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic                 sdo_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  output logic                 busy_o,
  output logic                 res_valid_o,
  output logic                 res_chan_o,
  output logic [DATA_BITS-1:0] res_data_o,
  output logic [SUB_BITS-1:0]  res_sub_o,
  output logic                 res_ferr_o
);
  localparam int WMAX = (WAKE_CYC > CSH_CYC) ? WAKE_CYC : CSH_CYC;
  localparam int WW   = $clog2(WMAX + 1);
  localparam logic [WW-1:0] WAKE_LD = WW'(WAKE_CYC - 1);
  localparam logic [WW-1:0] CSH_LD  = WW'(CSH_CYC - 1);
  localparam logic [FCNT_W-1:0] LAST_FALL = FCNT_W'(FRAME_BITS - 1);

  generate
    if (DIV_HALF < 1 || WAKE_CYC < 1 || CSH_CYC < 1) begin : g_bad_cfg
      $error("adc_rd_ctrl: cycle-count parameters must be at least 1");
    end
  endgenerate

  rd_state_e         st_q, st_d;
  logic [WW-1:0]     wcnt_q, wcnt_d;
  logic [FCNT_W-1:0] fcnt_q, fcnt_d;
  logic              done;
  logic              run;
  logic              rise_p, fall_p;
  rd_result_t        result;

  assign run = (st_q == ST_SHIFT) && !abort_i;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    fcnt_d = fcnt_q;
    done   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i && !abort_i) begin
          st_d   = ST_WAKE;
          wcnt_d = WAKE_LD;
        end
      end
      ST_WAKE: begin
        if (abort_i) begin
          st_d   = ST_GAP;
          wcnt_d = CSH_LD;
        end else if (wcnt_q == '0) begin
          st_d   = ST_SHIFT;
          fcnt_d = '0;
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (abort_i) begin
          st_d   = ST_GAP;
          wcnt_d = CSH_LD;
        end else if (fall_p) begin
          if (fcnt_q == LAST_FALL) begin
            st_d   = ST_GAP;
            wcnt_d = CSH_LD;
            done   = 1'b1;
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (wcnt_q == '0) st_d = ST_IDLE;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      fcnt_q <= fcnt_d;
    end
  end

  adc_rd_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .sclk   (sclk_o),
    .rise_p (rise_p),
    .fall_p (fall_p)
  );

  adc_rd_deframe u_defr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (rise_p),
    .sdo      (sdo_i),
    .load     (done),
    .result   (result),
    .valid    (res_valid_o)
  );

  assign cs_n_o     = !((st_q == ST_WAKE) || (st_q == ST_SHIFT));
  assign busy_o     = (st_q != ST_IDLE);
  assign res_chan_o = result.chan;
  assign res_data_o = result.data;
  assign res_sub_o  = result.sub;
  assign res_ferr_o = result.ferr;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int WAKE_CYC = 500,
  parameter int CSH_CYC  = 12
) (
  input logic clk,
  input logic rst_n,
  input logic abort_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic busy_o,
  input logic res_valid_o
);
  logic [31:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 32'(CSH_CYC);
    end else begin
      if (cs_n_o) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (!cs_n_o) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R2
  cs_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (!sclk_o && !$past(sclk_o)));

  // R4
  sclk_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);

  // R3
  wake_before_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (lo_cnt >= 32'(WAKE_CYC)));

  // R9
  cs_high_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= 32'(CSH_CYC)));

  // R6
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $rose(cs_n_o));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R11
  busy_covers_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  // R10
  abort_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !cs_n_o) |=> (cs_n_o && !sclk_o && !res_valid_o));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.WAKE_CYC(WAKE_CYC), .CSH_CYC(CSH_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .busy_o      (busy_o),
  .res_valid_o (res_valid_o)
);

// File: tb/adc_rd_ctrl_tb.sv
module adc_rd_ctrl_tb;
  localparam int DIV  = 3;
  localparam int WAKE = 5;
  localparam int CSH  = 4;
  localparam int M_IDLE = 0, M_WAKE = 1, M_SHIFT = 2, M_GAP = 3;

  logic clk, rst_n, start_i, abort_i, sdo_i;
  logic cs_n_o, sclk_o, busy_o, res_valid_o, res_chan_o, res_ferr_o;
  logic [9:0] res_data_o;
  logic [1:0] res_sub_o;

  int n_chk, n_fail;

  int m_st, m_k;
  logic m_abt, m_valid, e_chan, e_ferr;
  logic [9:0] e_data;
  logic [1:0] e_sub;
  logic [15:0] cur_word;

  adc_rd_ctrl #(.DIV_HALF(DIV), .WAKE_CYC(WAKE), .CSH_CYC(CSH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i), .sdo_i(sdo_i),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o), .res_valid_o(res_valid_o),
    .res_chan_o(res_chan_o), .res_data_o(res_data_o), .res_sub_o(res_sub_o),
    .res_ferr_o(res_ferr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e_cs, e_sclk;
    string t_cs, t_sclk;
    e_cs   = !(m_st == M_WAKE || m_st == M_SHIFT);
    e_sclk = (m_st == M_SHIFT) ? (((m_k / DIV) % 2) == 1) : 1'b0;
    t_cs   = (m_st == M_GAP) ? (m_abt ? "R10 cs_n" : "R9 cs_n") : "R2 cs_n";
    t_sclk = (m_st == M_WAKE) ? "R3 sclk" : "R4 sclk";
    chk(cs_n_o == e_cs, t_cs, cs_n_o, e_cs);
    chk(sclk_o == e_sclk, t_sclk, sclk_o, e_sclk);
    chk(busy_o == (m_st != M_IDLE), "R11 busy", busy_o, m_st != M_IDLE);
    chk(res_valid_o == m_valid, "R6 valid", res_valid_o, m_valid);
    chk(res_data_o == e_data, "R5 data", res_data_o, e_data);
    chk(res_chan_o == e_chan && res_sub_o == e_sub, "R7 chan/sub",
        {res_chan_o, res_sub_o}, {e_chan, e_sub});
    chk(res_ferr_o == e_ferr, "R8 ferr", res_ferr_o, e_ferr);
  endtask

  task automatic step(input logic st, input logic ab);
    @(negedge clk);
    compare();
    start_i = st;
    abort_i = ab;
    sdo_i   = (m_st == M_SHIFT) ? cur_word[15 - m_k / (2 * DIV)] : 1'b0;
    m_valid = 1'b0;
    case (m_st)
      M_IDLE: if (st && !ab) begin m_st = M_WAKE; m_k = 0; end
      M_WAKE: begin
        if (ab) begin m_st = M_GAP; m_k = 0; m_abt = 1'b1; end
        else if (m_k == WAKE - 1) begin m_st = M_SHIFT; m_k = 0; end
        else m_k++;
      end
      M_SHIFT: begin
        if (ab) begin m_st = M_GAP; m_k = 0; m_abt = 1'b1; end
        else if (m_k == 32 * DIV - 1) begin
          m_st = M_GAP; m_k = 0; m_abt = 1'b0; m_valid = 1'b1;
          e_chan = cur_word[12];
          e_data = cur_word[11:2];
          e_sub  = cur_word[1:0];
          e_ferr = (cur_word[15:13] != 3'b111);
        end else m_k++;
      end
      default: begin
        if (m_k == CSH - 1) begin m_st = M_IDLE; m_k = 0; end
        else m_k++;
      end
    endcase
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && m_st != M_IDLE; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic frame(input logic [15:0] w);
    cur_word = w;
    step(1'b1, 1'b0);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_st = M_IDLE; m_k = 0; m_abt = 1'b0; m_valid = 1'b0;
    e_chan = 1'b0; e_data = '0; e_sub = '0; e_ferr = 1'b0;
    cur_word = '0;
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; sdo_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1 cs/sclk", {cs_n_o, sclk_o}, 2'b10);
    chk(busy_o == 1'b0 && res_valid_o == 1'b0, "R1 busy/valid", {busy_o, res_valid_o}, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R5 R7: normal frames, both channels
    frame(16'b111_0_1010101000_10);
    frame(16'b111_1_1111111111_01);
    frame(16'b111_0_0000000001_11);
    // R8: corrupt header
    frame(16'b110_1_0110011001_00);
    frame(16'b011_0_1000000000_10);
    // R2: start during a frame is ignored
    cur_word = 16'b111_1_0011110000_01;
    step(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    drain();
    // R10: abort in idle, in wake, and mid-shift keeps old result
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    cur_word = 16'b111_0_0101010101_11;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    drain();
    step(1'b1, 1'b0);
    for (int i = 0; i < WAKE + 20; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    drain();
    // R9: start held high gives back-to-back frames with the high time kept
    cur_word = 16'b111_1_1100110011_10;
    for (int i = 0; i < 2 * (WAKE + 32 * DIV + CSH + 1) + 4; i++) step(1'b1, 1'b0);
    drain();
    frame(16'b111_0_0000000000_00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule